// File: doc/BRIEF.md
# Shift-Add Arithmetic Instruction Processor Core

This block is a small programmable core whose instruction set suits iterative shift-and-add arithmetic such as vector-rotation angle solvers. Every instruction is 16 bits wide. The core has sixteen 16-bit general registers. Program memory is external, with an 8-bit word address and a synchronous read that returns the word one clock after the address is presented. Software does comparisons by subtracting, masking the sign with `andh` and branching on zero or non-zero.

Instructions flow through three stages. The first decodes the fetched word. The second reads operands and forms the branch target. The third computes the result, writes the register file and resolves branches. A result produced in the third stage feeds straight into operand read of the next instruction, so dependent instructions issue one per clock with no stall. A taken branch sends the fetch address to the target and discards every younger instruction already in flight.

Each register write is shown on a result port for one clock. An integrating system uses this port to observe the program's progress.

Top module: `shasip_core`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `imem_addr` is 0 and `ret_valid` is 0.
- R2: When no branch is taken, `imem_addr` increases by one every clock (modulo 256), starting from 0.
- R3: Opcode 0011 (`op rd imm8` in bits 15:12, 11:8, 7:0) writes imm8 into the low byte of rd. Opcode 0100 writes imm8 into the high byte of rd. The other byte of rd is kept.
- R4: Opcode 0101 ANDs imm8 into the low byte of rd, and opcode 0110 ANDs imm8 into the high byte. The other byte of rd is unchanged.
- R5: Opcode 0001 writes rs1+rs2 and opcode 0010 writes rs1−rs2, both modulo 2^16. The fields are rd in bits 11:8, rs1 in bits 7:4 and rs2 in bits 3:0.
- R6: Opcode 0111 writes the low 16 bits of rs1×rs2 to rd, using the same field layout as R5.
- R7: Opcode 1000 shifts rd right by one bit and fills bit 15 with zero.
- R8: Opcode 1001 jumps to the address in bits 7:0. The next fetch address is the target. The instructions fetched after the branch write nothing.
- R9: Opcode 1010 jumps to bits 7:0 when rd (bits 11:8) is zero. Opcode 1011 jumps when rd is non-zero. When the branch is not taken, execution continues in order.
- R10: An instruction that reads the register written by the instruction just before it sees the new value, and each of them retires one clock after the previous one.
- R11: Opcode 0000 and opcodes 1100 to 1111 change no register and produce no result-port pulse, whatever their other fields hold.
- R12: For each register write, `ret_valid` is high for exactly one clock, with `ret_reg` holding rd and `ret_data` holding the written value. The first instruction at address 0 reports in the third clock after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 8 | Program memory word address |
| imem_rdata | input | 16 | Program word, returned one clock after its address |
| ret_valid | output | 1 | A register write happens in this clock |
| ret_reg | output | 4 | Index of the register written |
| ret_data | output | 16 | Value written |

## Verification
The assertions check the fetch address on every cycle: it steps by one, or moves to the branch target one clock after a taken branch. They also check that the two clocks after a taken branch carry no register write, that a right shift never leaves bit 15 set, that a branch-on-zero never redirects with a non-zero register, and that no-operation slots never write. The data results can only be shown by the bench's scenarios. These are the byte-merge and mask semantics, wrap-around of add, subtract and truncated multiply over a sweep of edge-case operands, forwarding between back-to-back dependent instructions, and the ignored opcodes leaving register contents intact.

// File: rtl/shasip_pkg.sv
package shasip_pkg;
   localparam int unsigned INSTR_W = 16;
   localparam int unsigned FIELD_W = 4;
   localparam int unsigned IMM_W   = 8;

   typedef enum logic [3:0] {
      OPC_NOP   = 4'h0,
      OPC_ADD   = 4'h1,
      OPC_SUB   = 4'h2,
      OPC_LDLO  = 4'h3,
      OPC_LDHI  = 4'h4,
      OPC_MSKLO = 4'h5,
      OPC_MSKHI = 4'h6,
      OPC_MUL   = 4'h7,
      OPC_SHR   = 4'h8,
      OPC_JMP   = 4'h9,
      OPC_BZ    = 4'hA,
      OPC_BNZ   = 4'hB
   } opcode_e;

   typedef struct packed {
      logic               valid;
      opcode_e            op;
      logic [FIELD_W-1:0] rd;
      logic [FIELD_W-1:0] ra;
      logic [FIELD_W-1:0] rb;
      logic [IMM_W-1:0]   imm;
      logic               wr_en;
   } uop_t;
endpackage

// File: rtl/shasip_decode.sv
module shasip_decode
   import shasip_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   input  logic               valid,
   output uop_t               uop
);
   logic [3:0] fop;
   assign fop = instr[15:12];

   always_comb begin
      uop       = '0;
      uop.valid = valid;
      uop.rd    = instr[11:8];
      uop.ra    = instr[11:8];
      uop.rb    = instr[3:0];
      uop.imm   = instr[7:0];
      case (fop)
         4'h1, 4'h2, 4'h7: begin
            uop.op    = opcode_e'(fop);
            uop.ra    = instr[7:4];
            uop.wr_en = 1'b1;
         end
         4'h3, 4'h4, 4'h5, 4'h6, 4'h8: begin
            uop.op    = opcode_e'(fop);
            uop.wr_en = 1'b1;
         end
         4'h9, 4'hA, 4'hB: begin
            uop.op    = opcode_e'(fop);
         end
         default: begin
            uop.op    = OPC_NOP;
         end
      endcase
   end
endmodule

// File: rtl/shasip_regfile.sv
module shasip_regfile #(
   parameter  int unsigned DATA_W  = 16,
   parameter  int unsigned REG_CNT = 16,
   localparam int unsigned IDX_W   = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [IDX_W-1:0]  ra_a,
   input  logic [IDX_W-1:0]  ra_b,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b
);
   logic [DATA_W-1:0] regs [REG_CNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(REG_CNT); i++) regs[i] <= '0;
      end else if (we) begin
         regs[wa] <= wd;
      end
   end

   assign rd_a = regs[ra_a];
   assign rd_b = regs[ra_b];
endmodule

// File: rtl/shasip_exec.sv
module shasip_exec
   import shasip_pkg::*;
#(
   parameter  int unsigned DATA_W = 16,
   localparam int unsigned HALF   = DATA_W / 2
) (
   input  opcode_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] result,
   output logic              take
);
   logic [HALF-1:0] lo, hi, k;
   assign lo = a[HALF-1:0];
   assign hi = a[DATA_W-1:HALF];
   assign k  = HALF'(imm);

   always_comb begin
      result = '0;
      take   = 1'b0;
      case (op)
         OPC_ADD:   result = a + b;
         OPC_SUB:   result = a - b;
         OPC_MUL:   result = a * b;
         OPC_LDLO:  result = {hi, k};
         OPC_LDHI:  result = {k, lo};
         OPC_MSKLO: result = {hi, lo & k};
         OPC_MSKHI: result = {hi & k, lo};
         OPC_SHR:   result = a >> 1;
         OPC_JMP:   take   = 1'b1;
         OPC_BZ:    take   = (a == '0);
         OPC_BNZ:   take   = (a != '0);
         default:   result = '0;
      endcase
   end
endmodule

// File: rtl/shasip_core.sv
module shasip_core
   import shasip_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned REG_CNT = 16,
   parameter int unsigned PC_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [PC_W-1:0]      imem_addr,
   input  logic [INSTR_W-1:0]   imem_rdata,
   output logic                 ret_valid,
   output logic [FIELD_W-1:0]   ret_reg,
   output logic [DATA_W-1:0]    ret_data
);
   localparam int unsigned IDX_W = $clog2(REG_CNT);

   generate
      if (DATA_W != 2 * IMM_W) begin : g_bad_width
         $error("DATA_W must be twice the immediate width");
      end
      if (IDX_W != FIELD_W) begin : g_bad_regs
         $error("REG_CNT must match the 4-bit register fields");
      end
      if (PC_W < IMM_W) begin : g_bad_pc
         $error("PC_W must hold an 8-bit branch target");
      end
   endgenerate

   // fetch
   logic [PC_W-1:0]   pc_q;
   logic              fd_valid_q;
   // decode -> address generation
   uop_t              uop_fd, ag_q;
   // address generation -> execute
   uop_t              ex_q;
   logic [DATA_W-1:0] ex_a_q, ex_b_q;
   logic [PC_W-1:0]   ex_tgt_q;
   // execute
   logic [DATA_W-1:0] ex_res;
   logic              ex_take, redirect, ex_wr;
   logic [DATA_W-1:0] rf_a, rf_b, opnd_a, opnd_b;

   shasip_decode u_dec (
      .instr (imem_rdata),
      .valid (fd_valid_q),
      .uop   (uop_fd)
   );

   shasip_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ex_wr),
      .wa    (ex_q.rd),
      .wd    (ex_res),
      .ra_a  (ag_q.ra),
      .ra_b  (ag_q.rb),
      .rd_a  (rf_a),
      .rd_b  (rf_b)
   );

   shasip_exec #(.DATA_W(DATA_W)) u_exe (
      .op     (ex_q.op),
      .a      (ex_a_q),
      .b      (ex_b_q),
      .imm    (ex_q.imm),
      .result (ex_res),
      .take   (ex_take)
   );

   assign redirect = ex_q.valid && ex_take;
   assign ex_wr    = ex_q.valid && ex_q.wr_en;

   // bypass from execute into operand read
   always_comb begin
      opnd_a = (ex_wr && ex_q.rd == ag_q.ra) ? ex_res : rf_a;
      opnd_b = (ex_wr && ex_q.rd == ag_q.rb) ? ex_res : rf_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q       <= '0;
         fd_valid_q <= 1'b0;
         ag_q       <= '0;
         ex_q       <= '0;
         ex_a_q     <= '0;
         ex_b_q     <= '0;
         ex_tgt_q   <= '0;
      end else begin
         pc_q       <= redirect ? ex_tgt_q : pc_q + 1'b1;
         fd_valid_q <= !redirect;
         ag_q       <= redirect ? '0 : uop_fd;
         ex_q       <= redirect ? '0 : ag_q;
         ex_a_q     <= opnd_a;
         ex_b_q     <= opnd_b;
         ex_tgt_q   <= PC_W'(ag_q.imm);
      end
   end

   assign imem_addr = pc_q;
   assign ret_valid = ex_wr;
   assign ret_reg   = ex_q.rd;
   assign ret_data  = ex_res;

   AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |=> imem_addr == $past(imem_addr) + 1'b1);                    // R2
   AST_REDIRECT_PC: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> imem_addr == $past(ex_tgt_q));                             // R8
   AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !ret_valid);                                               // R8
   AST_FLUSH_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> ##1 !ret_valid);                                           // R8
   AST_SHR_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ex_q.op == OPC_SHR) |-> !ret_data[DATA_W-1]);             // R7
   AST_BZ_NONZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_q.valid && ex_q.op == OPC_BZ && ex_a_q != '0) |-> !redirect);       // R9
   AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_q.valid && ex_q.op == OPC_NOP) |-> !ret_valid);                     // R11
endmodule

// File: tb/tb_shasip_core.sv
`timescale 1ns/1ps
module tb_shasip_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  imem_addr;
   logic [15:0] imem_rdata;
   logic        ret_valid;
   logic [3:0]  ret_reg;
   logic [15:0] ret_data;

   logic [15:0] rom [256];

   int checks = 0;
   int errors = 0;
   int wd_cnt = 0;

   int          exp_n, got_n;
   logic [3:0]  exp_reg [64];
   logic [15:0] exp_dat [64];
   string       exp_tag [64];
   logic [3:0]  got_reg [64];
   logic [15:0] got_dat [64];
   int          got_cyc [64];
   logic [7:0]  addr_log [64];

   shasip_core dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .ret_valid  (ret_valid),
      .ret_reg    (ret_reg),
      .ret_data   (ret_data)
   );

   always #4 clk = ~clk;

   always @(posedge clk) imem_rdata <= rom[imem_addr];

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 150000) begin
         errors++;
         $display("FAIL watchdog (all) actual=%0d expected<150000", wd_cnt);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] e3(logic [3:0] op, logic [3:0] d, logic [3:0] s1, logic [3:0] s2);
      return {op, d, s1, s2};
   endfunction

   function automatic logic [15:0] ei(logic [3:0] op, logic [3:0] d, logic [7:0] im);
      return {op, d, im};
   endfunction

   task automatic rom_clear();
      for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
   endtask

   // instruction-level model built from the requirements
   task automatic model_run();
      logic [15:0] m [16];
      int pc;
      logic [15:0] w, res;
      logic [3:0]  o, d, s1, s2;
      logic [7:0]  im;
      bit          wr;
      string       tg;
      for (int i = 0; i < 16; i++) m[i] = 16'h0;
      pc = 0;
      exp_n = 0;
      for (int st = 0; st < 300; st++) begin
         w = rom[pc]; o = w[15:12]; d = w[11:8]; s1 = w[7:4]; s2 = w[3:0]; im = w[7:0];
         wr = 1'b1; res = 16'h0; tg = "";
         case (o)
            4'h1: begin res = m[s1] + m[s2]; tg = "R5"; end
            4'h2: begin res = m[s1] - m[s2]; tg = "R5"; end
            4'h3: begin res = {m[d][15:8], im}; tg = "R3"; end
            4'h4: begin res = {im, m[d][7:0]}; tg = "R3"; end
            4'h5: begin res = {m[d][15:8], m[d][7:0] & im}; tg = "R4"; end
            4'h6: begin res = {m[d][15:8] & im, m[d][7:0]}; tg = "R4"; end
            4'h7: begin res = 16'(m[s1] * m[s2]); tg = "R6"; end
            4'h8: begin res = {1'b0, m[d][15:1]}; tg = "R7"; end
            default: wr = 1'b0;
         endcase
         if (wr) begin
            m[d] = res;
            if (exp_n < 64) begin
               exp_reg[exp_n] = d; exp_dat[exp_n] = res; exp_tag[exp_n] = tg;
            end
            exp_n++;
         end
         if (o == 4'h9) begin
            if (int'(im) == pc) break;
            pc = int'(im);
         end else if (o == 4'hA && m[d] == 16'h0) pc = int'(im);
         else if (o == 4'hB && m[d] != 16'h0) pc = int'(im);
         else pc = (pc + 1) % 256;
      end
   endtask

   task automatic run_prog(string ptag, int ncyc);
      model_run();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(imem_addr == 8'h00, "R1", "fetch address at reset release", imem_addr, 0);
      chk(ret_valid == 1'b0, "R1", "result pulse at reset release", ret_valid, 0);
      got_n = 0;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         if (c < 64) addr_log[c] = imem_addr;
         if (ret_valid) begin
            if (got_n < 64) begin
               got_reg[got_n] = ret_reg; got_dat[got_n] = ret_data; got_cyc[got_n] = c;
            end
            got_n++;
         end
      end
      chk(got_n == exp_n, ptag, "number of register writes", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
         chk(got_reg[i] == exp_reg[i], "R12", $sformatf("write %0d register", i), got_reg[i], exp_reg[i]);
         chk(got_dat[i] == exp_dat[i], exp_tag[i], $sformatf("write %0d data", i), got_dat[i], exp_dat[i]);
      end
   endtask

   logic [15:0] vals [8];

   initial begin
      vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
      vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'hA5C3; vals[7] = 16'h00FF;
      rom_clear();
      imem_rdata = 16'h0;

      // R2 / R11: all no-operation words, fetch address counts up, nothing written
      run_prog("R11", 40);
      for (int c = 0; c < 40; c++)
         chk(addr_log[c] == 8'(c + 1), "R2", $sformatf("fetch address cycle %0d", c), addr_log[c], c + 1);

      // arithmetic sweep: R3 R4 R5 R6 R7, forwarding R10, timing R12
      for (int ia = 0; ia < 8; ia++) begin
         for (int ib = 0; ib < 8; ib++) begin
            logic [15:0] a, b;
            a = vals[ia]; b = vals[ib];
            rom_clear();
            rom[0]  = ei(4'h3, 4'd1, a[7:0]);
            rom[1]  = ei(4'h4, 4'd1, a[15:8]);
            rom[2]  = ei(4'h3, 4'd2, b[7:0]);
            rom[3]  = ei(4'h4, 4'd2, b[15:8]);
            rom[4]  = e3(4'h1, 4'd15, 4'd1, 4'd2);
            rom[5]  = e3(4'h2, 4'd3, 4'd1, 4'd2);
            rom[6]  = e3(4'h7, 4'd4, 4'd1, 4'd2);
            rom[7]  = e3(4'h2, 4'd0, 4'd2, 4'd1);
            rom[8]  = ei(4'h8, 4'd1, 8'hFF);
            rom[9]  = ei(4'h5, 4'd2, a[7:0] ^ b[15:8]);
            rom[10] = ei(4'h6, 4'd2, b[7:0] ^ 8'h3C);
            rom[11] = ei(4'h8, 4'd15, 8'h00);
            rom[12] = ei(4'h3, 4'd15, 8'h3C);
            rom[13] = ei(4'h9, 4'd0, 8'd13);
            run_prog("R5", 40);
            chk(got_cyc[0] == 2, "R12", "first write clock after release", got_cyc[0], 2);
            for (int i = 1; i < 13 && i < got_n; i++)
               chk(got_cyc[i] == got_cyc[i-1] + 1, "R10", $sformatf("write %0d back-to-back", i),
                   got_cyc[i], got_cyc[i-1] + 1);
         end
      end

      // branches: R8 R9, plus forwarding into a branch (R10)
      rom_clear();
      rom[0]  = ei(4'h3, 4'd1, 8'h00);
      rom[1]  = ei(4'hA, 4'd1, 8'd8);
      rom[2]  = ei(4'h3, 4'd2, 8'h11);
      rom[3]  = ei(4'h3, 4'd3, 8'h22);
      rom[4]  = ei(4'h3, 4'd7, 8'h77);
      rom[8]  = ei(4'h3, 4'd4, 8'h44);
      rom[9]  = ei(4'hB, 4'd4, 8'd16);
      rom[10] = ei(4'h3, 4'd2, 8'h12);
      rom[11] = ei(4'h3, 4'd3, 8'h23);
      rom[16] = ei(4'hB, 4'd0, 8'd40);
      rom[17] = ei(4'h3, 4'd5, 8'h55);
      rom[18] = ei(4'hA, 4'd4, 8'd40);
      rom[19] = ei(4'h3, 4'd6, 8'h66);
      rom[20] = ei(4'h9, 4'd0, 8'd24);
      rom[21] = ei(4'h3, 4'd8, 8'h88);
      rom[22] = ei(4'h3, 4'd9, 8'h99);
      rom[24] = e3(4'h1, 4'd9, 4'd4, 4'd5);
      rom[25] = ei(4'h9, 4'd0, 8'd25);
      rom[40] = ei(4'h3, 4'd10, 8'hEE);
      run_prog("R8", 60);
      chk(exp_n == 5, "R9", "model write count for branch program", exp_n, 5);
      chk(addr_log[59] >= 8'd25 && addr_log[59] <= 8'd27, "R8", "fetch held in halt loop", addr_log[59], 25);

      // ignored opcodes leave registers intact: R11
      rom_clear();
      rom[0] = ei(4'h3, 4'd1, 8'h5A);
      rom[1] = 16'hC123;
      rom[2] = 16'hDFFF;
      rom[3] = 16'hE111;
      rom[4] = 16'hF1FF;
      rom[5] = 16'h0F12;
      rom[6] = ei(4'h4, 4'd1, 8'hA5);
      rom[7] = e3(4'h1, 4'd2, 4'd1, 4'd0);
      rom[8] = ei(4'h9, 4'd0, 8'd8);
      run_prog("R11", 40);
      chk(got_n == 3 && got_dat[2] == 16'hA55A, "R11", "register after ignored opcodes", got_dat[2], 16'hA55A);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule